// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is a serial peripheral interface master that software drives through a small synchronous register bus. Software picks the clock polarity, clock phase, bit order, word size and serial clock divisor in a control register and a divisor register. Each word then goes through a shift register. That register drives the outgoing data line and samples the incoming one on a serial clock that the block generates. The slave-select pins are fully under software control: each pin has an ownership bit and a level bit.

In the default start mode, a write to the transmit buffer starts a word. The interrupt request is high whenever the transmit buffer is empty, so an interrupt handler can refill the buffer one word at a time. In the alternate start mode, a read of the receive buffer starts a word. If the transmit buffer is empty at that moment, the block shifts out either zeros or the last word it sent.

A finished word lands in the receive buffer, and a control bit decides what happens when that buffer is still full. Errors are held in sticky status bits that are cleared only by writing a one.

Top module: `spim_top`

## Requirements
- R1: After reset, STATUS (address 1) reads 0x0001, every ss_n pin is high, irq is low and sclk is low.
- R2: While a word is shifting, each half period of sclk lasts max(DIV, 2) clock cycles, where DIV is the value at address 3.
- R3: With CTRL (address 0) bit 0 (enable) set and start-mode bit 7 clear, a write to TXBUF (address 4) starts a word. CTRL bit 4 selects the size: 1 sends all 16 bits, 0 sends the low 8. CTRL bit 3 selects the order: 0 sends the most significant bit first, 1 sends the least significant bit first.
- R4: At the end of a word, the bits sampled from miso, in the same size and order, appear in RXBUF (address 5) and STATUS bit 1 (receive full) is set. A read of RXBUF clears STATUS bit 1.
- R5: sclk rests at CTRL bit 1 (polarity). With CTRL bit 2 (phase) at 0, miso is sampled on the first sclk edge of each bit. With phase at 1, it is sampled on the second edge. mosi changes only at bit boundaries.
- R6: In the default start mode, irq equals enable AND transmit-empty (STATUS bit 0). A TXBUF write drops irq in the next cycle. irq rises again once the word moves into the shift register.
- R7: SEL (address 2) bit i gives pin ss_n[i] to the block. Bit 8+i then sets that pin's level (0 drives low, 1 drives high). A pin that is not given to the block stays high.
- R8: When a word ends while the receive buffer is full, STATUS bit 3 (overflow) is set. With CTRL bit 6 at 0 the new word is dropped. With CTRL bit 6 at 1 the new word replaces the stored one.
- R9: STATUS bits 3 and 4 are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R10: With CTRL bit 7 set, a read of RXBUF starts a word. If the transmit buffer is empty, STATUS bit 4 (underrun) is set and the word sent is zero when CTRL bit 5 is 0. When CTRL bit 5 is 1, the word sent is the last word taken from TXBUF.
- R11: While enable is clear, no word starts, a written TXBUF stays pending, and sclk rests at the polarity level. Setting enable afterwards sends the pending word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier (used for read side effects) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | WORD_W | Write data |
| bus_rdata | output | WORD_W | Read data, combinational from the address |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Slave-select pins |

## Verification
The bench builds the block with its defaults: a 16-bit word, four select pins and a 16-bit divisor. It keeps the divisor at 1, 2 or 3, so every word finishes in a few dozen cycles and all four polarity/phase pairs, both bit orders and both sizes fit in one run. Divisor 1 exercises the clamp to the quarter-rate limit, and divisor 3 exercises an odd half period. Pin 0 is the select line of a modelled slave, which leaves pins 1 to 3 free for the ownership and level checks.

// File: rtl/spim_pkg.sv
package spim_pkg;
    // register addresses
    localparam logic [2:0] ADDR_CTRL = 3'd0;
    localparam logic [2:0] ADDR_STAT = 3'd1;
    localparam logic [2:0] ADDR_SEL  = 3'd2;
    localparam logic [2:0] ADDR_DIV  = 3'd3;
    localparam logic [2:0] ADDR_TX   = 3'd4;
    localparam logic [2:0] ADDR_RX   = 3'd5;

    // control register bit positions
    localparam int C_EN    = 0;
    localparam int C_CPOL  = 1;
    localparam int C_CPHA  = 2;
    localparam int C_LSB   = 3;
    localparam int C_WIDE  = 4;
    localparam int C_SLAST = 5;
    localparam int C_KEEP  = 6;
    localparam int C_RXS   = 7;

    // status register bit positions
    localparam int S_TXE  = 0;
    localparam int S_RXF  = 1;
    localparam int S_BUSY = 2;
    localparam int S_OVF  = 3;
    localparam int S_UDR  = 4;

    // select register: level bits start here
    localparam int SEL_VAL_LSB = 8;

    typedef struct packed {
        logic en;
        logic cpol;
        logic cpha;
        logic lsb;
        logic wide;
        logic slast;
        logic keep;
        logic rxs;
    } ctrl_t;
endpackage

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(2);

    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] eff;

    always_comb begin
        eff   = (div < MIN_HALF) ? MIN_HALF : div;
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == eff - DIV_W'(1)) begin
            tick  = 1'b1;
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spim_engine.sv
module spim_engine #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              start,
    input  logic [WORD_W-1:0] start_word,
    input  logic              lsb,
    input  logic              wide,
    input  logic              cpha,
    input  logic              tick,
    input  logic              miso,
    output logic              busy,
    output logic              sclk_act,
    output logic              mosi,
    output logic              done,
    output logic [WORD_W-1:0] rx_word
);
    localparam int HALF_W = WORD_W / 2;
    localparam int CNT_W  = $clog2(WORD_W);

    typedef struct packed {
        logic              busy;
        logic              half;
        logic [CNT_W-1:0]  bitn;
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] rx;
        logic              mosi;
    } eng_t;

    eng_t s_d, s_q;
    logic [CNT_W-1:0]  last_bit;
    logic [WORD_W-1:0] sh_next;

    function automatic logic lead_bit(input logic [WORD_W-1:0] w, input logic l, input logic wd);
        if (l)       return w[0];
        else if (wd) return w[WORD_W-1];
        else         return w[HALF_W-1];
    endfunction

    always_comb begin
        last_bit = wide ? CNT_W'(WORD_W-1) : CNT_W'(HALF_W-1);
        sh_next  = lsb ? {1'b0, s_q.sh[WORD_W-1:1]} : {s_q.sh[WORD_W-2:0], 1'b0};
        done     = 1'b0;
        s_d      = s_q;
        if (abort) begin
            s_d.busy = 1'b0;
            s_d.half = 1'b0;
        end else if (start) begin
            s_d.busy = 1'b1;
            s_d.half = 1'b0;
            s_d.bitn = '0;
            s_d.sh   = start_word;
            s_d.rx   = '0;
            s_d.mosi = lead_bit(start_word, lsb, wide);
        end else if (s_q.busy && tick) begin
            if (!s_q.half) begin
                s_d.half = 1'b1;
                s_d.rx   = lsb ? {miso, s_q.rx[WORD_W-1:1]} : {s_q.rx[WORD_W-2:0], miso};
            end else begin
                s_d.half = 1'b0;
                if (s_q.bitn == last_bit) begin
                    s_d.busy = 1'b0;
                    done     = 1'b1;
                end else begin
                    s_d.bitn = s_q.bitn + CNT_W'(1);
                    s_d.sh   = sh_next;
                    s_d.mosi = lead_bit(sh_next, lsb, wide);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        if (wide)     rx_word = s_q.rx;
        else if (lsb) rx_word = {{(WORD_W-HALF_W){1'b0}}, s_q.rx[WORD_W-1:HALF_W]};
        else          rx_word = {{(WORD_W-HALF_W){1'b0}}, s_q.rx[HALF_W-1:0]};
    end

    assign busy     = s_q.busy;
    assign sclk_act = s_q.busy & (s_q.half ^ cpha);
    assign mosi     = s_q.mosi;

    // R3: a start request only arrives while idle
    a_r3_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !s_q.busy);

    // R2: the clock phase only moves on a divider tick
    a_r2_half_holds: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy && $past(s_q.busy) && !$past(tick) |-> $stable(s_q.half));
endmodule

// File: rtl/spim_top.sv
module spim_top #(
    parameter int WORD_W = 16,
    parameter int NUM_SS = 4,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_SS-1:0] ss_n
);
    import spim_pkg::*;

    localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(4);

    typedef struct packed {
        ctrl_t             c;
        logic [NUM_SS-1:0] sel_en;
        logic [NUM_SS-1:0] sel_val;
        logic [DIV_W-1:0]  div;
        logic [WORD_W-1:0] txbuf;
        logic [WORD_W-1:0] rxbuf;
        logic [WORD_W-1:0] last;
        logic              tx_empty;
        logic              rx_full;
        logic              ovf;
        logic              udr;
    } regs_t;

    regs_t r_d, r_q;

    logic              wr_ctrl, wr_stat, wr_sel, wr_div, wr_tx, rd_rx;
    logic              eng_start, eng_busy, eng_done, eng_act, tick;
    logic              full_now;
    logic [WORD_W-1:0] start_word, eng_rx;

    spim_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (eng_busy),
        .div  (r_q.div),
        .tick (tick)
    );

    spim_engine #(.WORD_W(WORD_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (!r_q.c.en),
        .start     (eng_start),
        .start_word(start_word),
        .lsb       (r_q.c.lsb),
        .wide      (r_q.c.wide),
        .cpha      (r_q.c.cpha),
        .tick      (tick),
        .miso      (miso),
        .busy      (eng_busy),
        .sclk_act  (eng_act),
        .mosi      (mosi),
        .done      (eng_done),
        .rx_word   (eng_rx)
    );

    always_comb begin
        wr_ctrl = bus_sel && bus_wr && (bus_addr == ADDR_CTRL);
        wr_stat = bus_sel && bus_wr && (bus_addr == ADDR_STAT);
        wr_sel  = bus_sel && bus_wr && (bus_addr == ADDR_SEL);
        wr_div  = bus_sel && bus_wr && (bus_addr == ADDR_DIV);
        wr_tx   = bus_sel && bus_wr && (bus_addr == ADDR_TX);
        rd_rx   = bus_sel && bus_rd && (bus_addr == ADDR_RX);

        eng_start = r_q.c.en && !eng_busy &&
                    (r_q.c.rxs ? rd_rx : !r_q.tx_empty);
        if (!r_q.tx_empty)    start_word = r_q.txbuf;
        else if (r_q.c.slast) start_word = r_q.last;
        else                  start_word = '0;

        r_d = r_q;

        // word start: take the buffer or record an underrun
        if (eng_start) begin
            if (!r_q.tx_empty) begin
                r_d.tx_empty = 1'b1;
                r_d.last     = r_q.txbuf;
            end else begin
                r_d.udr = 1'b1;
            end
        end

        if (rd_rx) r_d.rx_full = 1'b0;

        // write-one-to-clear of the sticky bits
        if (wr_stat) begin
            if (bus_wdata[S_OVF]) r_d.ovf = 1'b0;
            if (bus_wdata[S_UDR]) r_d.udr = 1'b0;
        end

        // word end: deposit or apply the full-buffer policy
        full_now = r_q.rx_full && !rd_rx;
        if (eng_done) begin
            if (full_now) r_d.ovf = 1'b1;
            if (!full_now || r_q.c.keep) begin
                r_d.rxbuf   = eng_rx;
                r_d.rx_full = 1'b1;
            end
        end

        if (wr_tx) begin
            r_d.txbuf    = bus_wdata;
            r_d.tx_empty = 1'b0;
        end
        if (wr_ctrl) begin
            r_d.c.en    = bus_wdata[C_EN];
            r_d.c.cpol  = bus_wdata[C_CPOL];
            r_d.c.cpha  = bus_wdata[C_CPHA];
            r_d.c.lsb   = bus_wdata[C_LSB];
            r_d.c.wide  = bus_wdata[C_WIDE];
            r_d.c.slast = bus_wdata[C_SLAST];
            r_d.c.keep  = bus_wdata[C_KEEP];
            r_d.c.rxs   = bus_wdata[C_RXS];
        end
        if (wr_sel) begin
            r_d.sel_en  = bus_wdata[NUM_SS-1:0];
            r_d.sel_val = bus_wdata[SEL_VAL_LSB +: NUM_SS];
        end
        if (wr_div) r_d.div = bus_wdata[DIV_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.div      <= DIV_RST;
            r_q.tx_empty <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL: begin
                bus_rdata[C_EN]    = r_q.c.en;
                bus_rdata[C_CPOL]  = r_q.c.cpol;
                bus_rdata[C_CPHA]  = r_q.c.cpha;
                bus_rdata[C_LSB]   = r_q.c.lsb;
                bus_rdata[C_WIDE]  = r_q.c.wide;
                bus_rdata[C_SLAST] = r_q.c.slast;
                bus_rdata[C_KEEP]  = r_q.c.keep;
                bus_rdata[C_RXS]   = r_q.c.rxs;
            end
            ADDR_STAT: begin
                bus_rdata[S_TXE]  = r_q.tx_empty;
                bus_rdata[S_RXF]  = r_q.rx_full;
                bus_rdata[S_BUSY] = eng_busy;
                bus_rdata[S_OVF]  = r_q.ovf;
                bus_rdata[S_UDR]  = r_q.udr;
            end
            ADDR_SEL: begin
                bus_rdata[NUM_SS-1:0]           = r_q.sel_en;
                bus_rdata[SEL_VAL_LSB +: NUM_SS] = r_q.sel_val;
            end
            ADDR_DIV: bus_rdata[DIV_W-1:0] = r_q.div;
            ADDR_TX:  bus_rdata = r_q.txbuf;
            ADDR_RX:  bus_rdata = r_q.rxbuf;
            default:  bus_rdata = '0;
        endcase
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SS; gi++) begin : g_ss
            assign ss_n[gi] = r_q.sel_en[gi] ? r_q.sel_val[gi] : 1'b1;
        end
    endgenerate

    assign sclk = r_q.c.cpol ^ eng_act;
    assign irq  = r_q.c.en & (r_q.c.rxs ? r_q.rx_full : r_q.tx_empty);

    // R4: a finished word leaves the receive buffer full
    a_r4_done_fills: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> r_q.rx_full);

    // R8: overflow stays set until a one is written to it
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ovf && !(wr_stat && bus_wdata[S_OVF]) |=> r_q.ovf);

    // R6: a transmit write removes the request in the next cycle
    a_r6_write_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tx && !r_q.c.rxs |=> !irq);

    // R10: a start from an empty buffer flags underrun
    a_r10_underrun: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start && r_q.tx_empty |=> r_q.udr);

    // R11: with the block disabled the clock rests at the polarity level
    a_r11_rest_level: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.c.en && !$past(r_q.c.en) |-> sclk == r_q.c.cpol);
endmodule

// File: tb/tb_spim_top.sv
`timescale 1ns/100ps
module tb_spim_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        irq, sclk, mosi;
    logic        miso = 1'b0;
    logic [3:0]  ss_n;

    int vecs = 0;
    int fails = 0;
    int dv = 2;

    spim_top dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic [15:0] exp;
        logic [15:0] mi;
        int          n;
        bit          lsb;
        bit          cpha;
    } item_t;
    item_t q[$];

    bit cur_cpol, cur_cpha, cur_lsb, cur_wide;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bw(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic br(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic set_ctrl(input bit en, input bit cpol, input bit cpha, input bit lsb,
                            input bit wide, input bit slast, input bit keep, input bit rxs);
        cur_cpol = cpol; cur_cpha = cpha; cur_lsb = lsb; cur_wide = wide;
        bw(3'd0, {8'h00, rxs, keep, slast, wide, lsb, cpha, cpol, en});
    endtask

    task automatic set_div(input int d);
        dv = (d < 2) ? 2 : d;
        bw(3'd3, 16'(d));
    endtask

    function automatic int nbits();
        return cur_wide ? 16 : 8;
    endfunction

    function automatic logic [15:0] msk(input logic [15:0] v);
        return cur_wide ? v : {8'h00, v[7:0]};
    endfunction

    task automatic push(input logic [15:0] exp, input logic [15:0] mi);
        item_t it;
        it.exp = msk(exp); it.mi = mi; it.n = nbits(); it.lsb = cur_lsb; it.cpha = cur_cpha;
        q.push_back(it);
    endtask

    // one word started by a transmit write
    task automatic xfer(input logic [15:0] tx, input logic [15:0] mi, input bit rdchk,
                        input int meas, input bit irqchk);
        logic [15:0] v;
        push(tx, mi);
        bw(3'd2, 16'h0001);
        bw(3'd4, tx);
        if (irqchk) begin
            check("R6 irq low after write", irq, 1'b0);
            @(negedge clk);
            check("R6 irq back once word loaded", irq, 1'b1);
        end
        if (meas != 0) begin
            int cnt = 0;
            wait (sclk != cur_cpol);
            while (sclk != cur_cpol) begin
                @(posedge clk); #1; cnt++;
            end
            check("R2 half period", cnt, meas);
        end
        repeat (nbits() * 2 * dv + 8) @(negedge clk);
        bw(3'd2, 16'h0000);
        repeat (2) @(negedge clk);
        if (rdchk) begin
            br(3'd5, v);
            check("R4 receive word", v, msk(mi));
        end
    endtask

    function automatic logic mbit(input item_t it, input int k);
        return it.lsb ? it.mi[k] : it.mi[it.n-1-k];
    endfunction

    // slave model and scoreboard monitor
    always begin : mon
        item_t it;
        logic [15:0] acc;
        @(negedge ss_n[0]);
        wait (q.size() > 0);
        it = q.pop_front();
        acc = '0;
        miso = mbit(it, 0);
        for (int k = 0; k < it.n; k++) begin
            if (!it.cpha) begin
                @(sclk);
                if (it.lsb) acc[k] = mosi; else acc = {acc[14:0], mosi};
                @(sclk);
                if (k + 1 < it.n) miso = mbit(it, k + 1);
            end else begin
                @(sclk);
                miso = mbit(it, k);
                @(sclk);
                if (it.lsb) acc[k] = mosi; else acc = {acc[14:0], mosi};
            end
        end
        check("R3 mosi word", acc, it.exp);
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin : main
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        br(3'd1, v);
        check("R1 status reset", v, 16'h0001);
        check("R1 ss_n reset", ss_n, 4'hF);
        check("R1 irq reset", irq, 1'b0);
        check("R1 sclk reset", sclk, 1'b0);

        set_div(2);
        set_ctrl(1, 0, 0, 0, 0, 0, 0, 0);
        check("R6 irq on empty after enable", irq, 1'b1);
        xfer(16'h00A5, 16'h003C, 1'b0, 0, 1'b1);
        br(3'd1, v);
        check("R4 receive full set", v[1], 1'b1);
        br(3'd5, v);
        check("R4 receive word", v, 16'h003C);
        br(3'd1, v);
        check("R4 receive full cleared by read", v[1], 1'b0);

        // R5 all clock modes, 16-bit MSB first
        for (int m = 0; m < 4; m++) begin
            set_ctrl(1, m[1], m[0], 0, 1, 0, 0, 0);
            check("R5 idle level", sclk, m[1]);
            xfer(16'hC3A5 ^ 16'(m), 16'h5A0F + 16'(m * 16'h1111), 1'b1, 0, 1'b0);
            check("R5 idle level after word", sclk, m[1]);
        end
        // R3 LSB first, both sizes
        set_ctrl(1, 0, 1, 1, 0, 0, 0, 0);
        xfer(16'h00B4, 16'h0096, 1'b1, 0, 1'b0);
        set_ctrl(1, 1, 0, 1, 1, 0, 0, 0);
        xfer(16'h8E71, 16'h29D3, 1'b1, 0, 1'b0);

        // R2 divisor, odd value and clamp
        set_ctrl(1, 0, 0, 0, 0, 0, 0, 0);
        set_div(3);
        xfer(16'h0066, 16'h00E1, 1'b1, 3, 1'b0);
        set_div(1);
        xfer(16'h0099, 16'h001E, 1'b1, 2, 1'b0);

        // R7 select pins 1..3
        bw(3'd2, 16'h040E);
        check("R7 owned pins follow level bits", ss_n, 4'b0101);
        bw(3'd2, 16'h0E00);
        check("R7 unowned pins stay high", ss_n, 4'b1111);

        // R8 / R9 overflow, drop policy
        set_div(2);
        set_ctrl(1, 0, 0, 0, 0, 0, 0, 0);
        xfer(16'h0011, 16'h0081, 1'b0, 0, 1'b0);
        xfer(16'h0022, 16'h0042, 1'b0, 0, 1'b0);
        br(3'd1, v);
        check("R8 overflow set", v[3], 1'b1);
        bw(3'd1, 16'h0000);
        br(3'd1, v);
        check("R9 writing zero keeps sticky bit", v[3], 1'b1);
        bw(3'd1, 16'h0008);
        br(3'd1, v);
        check("R9 writing one clears sticky bit", v[3], 1'b0);
        br(3'd5, v);
        check("R8 drop keeps first word", v, 16'h0081);
        // R8 replace policy
        set_ctrl(1, 0, 0, 0, 0, 0, 1, 0);
        xfer(16'h0013, 16'h0055, 1'b0, 0, 1'b0);
        xfer(16'h0024, 16'h00AA, 1'b0, 0, 1'b0);
        br(3'd5, v);
        check("R8 replace keeps newest word", v, 16'h00AA);
        bw(3'd1, 16'h0018);

        // R10 read-started words from an empty buffer
        set_ctrl(1, 0, 0, 0, 0, 0, 0, 1);
        push(16'h0000, 16'h006D);
        bw(3'd2, 16'h0001);
        br(3'd5, v);
        repeat (8 * 2 * dv + 8) @(negedge clk);
        bw(3'd2, 16'h0000);
        br(3'd1, v);
        check("R10 underrun set", v[4], 1'b1);
        bw(3'd1, 16'h0010);
        set_ctrl(1, 0, 0, 0, 0, 1, 0, 0);
        br(3'd5, v);
        check("R10 zeros word received", v, 16'h006D);
        set_ctrl(1, 0, 0, 0, 0, 1, 0, 1);
        push(16'h0024, 16'h0019);
        bw(3'd2, 16'h0001);
        br(3'd5, v);
        repeat (8 * 2 * dv + 8) @(negedge clk);
        bw(3'd2, 16'h0000);
        set_ctrl(1, 0, 0, 0, 0, 0, 0, 0);
        br(3'd5, v);
        check("R10 last-word mode received", v, 16'h0019);
        bw(3'd1, 16'h0018);

        // R11 disabled: nothing starts, clock rests at polarity
        set_ctrl(0, 1, 0, 0, 0, 0, 0, 0);
        check("R11 rest level while disabled", sclk, 1'b1);
        push(16'h005A, 16'h00C6);
        bw(3'd2, 16'h0001);
        bw(3'd4, 16'h005A);
        repeat (40) @(negedge clk);
        br(3'd1, v);
        check("R11 word held pending", v[2:0], 3'b000);
        check("R11 clock still at rest", sclk, 1'b1);
        set_ctrl(1, 1, 0, 0, 0, 0, 0, 0);
        repeat (8 * 2 * dv + 8) @(negedge clk);
        bw(3'd2, 16'h0000);
        br(3'd5, v);
        check("R11 pending word sent on enable", v, 16'h00C6);

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule